// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer

This block is a down counter with a reload buffer, meant to produce a periodic interrupt. Software writes a reload value into a buffer register and then sets the run bit. Setting the run bit copies the buffer into the counter. While the run bit is held, the counter steps down by one on each count tick. When it steps past zero it does not wrap. It loads the buffer again, and it raises a sticky expiry flag. The interrupt request is that flag gated by an interrupt-enable bit.

Two sources can drive the count tick, chosen by a select input. One is an internal tick from a free-running divider of the system clock. The other is an external clock pin, which is first synchronized and then edge-detected, so that each rising edge gives exactly one tick. The buffer address is asymmetric: a write goes to the buffer, and a read returns the live count. A new reload value can therefore be staged at any time and takes effect at the next reload. The register bus is a plain single-cycle write strobe with combinational read data. There is no back-pressure, so every write is accepted in the cycle it is presented.

Top module: `tmr_reload_timer`

## Requirements
- R1: After reset the count is 0. The control register reads 0, and the interrupt request is low.
- R2: A write to LOAD_ADDR stores the value in the reload buffer. A read from LOAD_ADDR returns the live count, never the buffer.
- R3: A control write that sets the run bit (bit 0) while it is clear loads the counter from the buffer on that clock edge.
- R4: With the run bit set and the select input low, the count drops by one on every INT_DIV-th system clock.
- R5: A tick that arrives while the count is 0 loads the counter from the buffer and sets the expiry flag (control bit 2).
- R6: A buffer write while the timer runs leaves the live count unchanged. The new value is used at the next reload.
- R7: While the run bit is clear, the count holds.
- R8: The interrupt request equals the expiry flag ANDed with the interrupt-enable bit (control bit 1). With the enable clear, no request is raised.
- R9: A control write with bit 2 at 0 clears the flag, and writing 1 there has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R10: With the select input high, each rising edge of the external pin gives exactly one decrement. The edge acts after a two-stage synchronizer, and a pin held high gives no further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| src_sel | input | 1 | Tick source: 0 internal divider, 1 external pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (CTRL_ADDR or LOAD_ADDR) |
| reg_wdata | input | WIDTH | Register write data |
| reg_rdata | output | WIDTH | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request (level) |

## Verification
The bench builds the timer with WIDTH=4 and INT_DIV=1, so the internal source ticks on every clock. This makes the whole reload range, 0 to 15, cheap to sweep, with one exact expected count per cycle. The sweep covers each reload value through load, countdown, expiry and stop. With a reload of 0 the counter expires on every tick, which brings the clear-versus-expiry collision of R9 within reach during an ordinary stop write. Directed passes then cover buffer staging, the gated interrupt, and single-tick behaviour of a held external pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RUN_BIT  = 0;
  localparam int IEN_BIT  = 1;
  localparam int FLAG_BIT = 2;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
#(
  parameter int INT_DIV = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ext_pin,
  input  tick_src_e src,
  output logic      tick
);
  logic [2:0] sync_q;
  logic       ext_rise;
  logic       int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_pin};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];

  generate
    if (INT_DIV <= 1) begin : g_nodiv
      assign int_tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(INT_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign int_tick = (div_q == DIV_LAST);
    end
  endgenerate

  assign tick = (src == SRC_EXTERNAL) ? ext_rise : int_tick;

  p_single_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  logic             flag_clr,
  input  logic [WIDTH-1:0] reload,
  output logic [WIDTH-1:0] count,
  output logic             flag,
  output logic             expire
);
  logic [WIDTH-1:0] cnt_q;
  logic             flag_q;
  logic             step;

  assign step   = run && tick && !start;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start)   cnt_q <= reload;
    else if (expire)  cnt_q <= reload;
    else if (step)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign count = cnt_q;
  assign flag  = flag_q;

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(reload)));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt_q));
  p_flag_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
endmodule

// File: rtl/tmr_reload_timer.sv
module tmr_reload_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0,
  parameter int LOAD_ADDR = 4,
  parameter int INT_DIV   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_pin,
  input  logic              src_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(LOAD_ADDR);

  logic             run_q, ien_q;
  logic [WIDTH-1:0] buf_q;
  logic             ctrl_wr, load_wr, start, flag_clr;
  logic             tick, flag, expire;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] ctrl_view;

  assign ctrl_wr  = reg_we && (reg_addr == CTRL_A);
  assign load_wr  = reg_we && (reg_addr == LOAD_A);
  assign start    = ctrl_wr && reg_wdata[RUN_BIT] && !run_q;
  assign flag_clr = ctrl_wr && !reg_wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
      buf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q <= reg_wdata[RUN_BIT];
        ien_q <= reg_wdata[IEN_BIT];
      end
      if (load_wr) buf_q <= reg_wdata;
    end
  end

  tmr_tick_sel #(.INT_DIV(INT_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_pin (ext_clk_pin),
    .src     (tick_src_e'(src_sel)),
    .tick    (tick)
  );

  tmr_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .start    (start),
    .tick     (tick),
    .flag_clr (flag_clr),
    .reload   (buf_q),
    .count    (count),
    .flag     (flag),
    .expire   (expire)
  );

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[RUN_BIT]  = run_q;
    ctrl_view[IEN_BIT]  = ien_q;
    ctrl_view[FLAG_BIT] = flag;
  end

  always_comb begin
    if (reg_addr == CTRL_A)      reg_rdata = ctrl_view;
    else if (reg_addr == LOAD_A) reg_rdata = count;
    else                         reg_rdata = '0;
  end

  assign irq = flag && ien_q;

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ien_q && !(ctrl_wr && !reg_wdata[IEN_BIT])) |=> irq);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[IEN_BIT]) |=> !irq);
endmodule

// File: tb/tmr_reload_timer_test.sv
module tmr_reload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int AW = 3;
  localparam int CA = 0;
  localparam int LA = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_clk_pin = 1'b0;
  logic          src_sel = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  tmr_reload_timer #(.WIDTH(W), .ADDR_W(AW), .CTRL_ADDR(CA), .LOAD_ADDR(LA), .INT_DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .ext_clk_pin(ext_clk_pin), .src_sel(src_sel),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = W'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = AW'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ext();
    ext_clk_pin = 1'b1; step(5);
    ext_clk_pin = 1'b0; step(5);
  endtask

  initial begin
    int v;
    int hold;
    step(3);
    rst_n = 1'b1;
    step(1);
    rd(LA, v); check("R1 count", v, 0);
    rd(CA, v); check("R1 ctrl", v, 0);
    check("R1 irq", int'(irq), 0);

    // R3 R4 R5 R7 R9 sweep over every reload value
    for (int p = 0; p < 16; p++) begin
      wr(LA, p);
      wr(CA, 3);
      rd(LA, v); check("R3 load on run", v, p);
      for (int k = 1; k <= p; k++) begin
        step(1);
        rd(LA, v); check("R4 decrement", v, p - k);
        rd(CA, v); check("R5 no early flag", v, 3);
      end
      step(1);
      rd(LA, v); check("R5 reload", v, p);
      rd(CA, v); check("R5 flag set", v, 7);
      check("R8 irq", int'(irq), 1);
      wr(CA, 0);
      hold = (p == 0) ? 0 : p - 1;
      rd(CA, v); check("R9 clear vs expiry", v, (p == 0) ? 4 : 0);
      step(3);
      rd(LA, v); check("R7 hold", v, hold);
      wr(CA, 0);
      rd(CA, v); check("R9 clear", v, 0);
    end

    // R9: writing 1 to the flag bit has no effect
    wr(CA, 4);
    rd(CA, v); check("R9 write one", v, 0);

    // R8: interrupt enable clear
    wr(LA, 2);
    wr(CA, 1);
    step(3);
    rd(LA, v); check("R5 reload ie0", v, 2);
    rd(CA, v); check("R8 flag without ie", v, 5);
    check("R8 irq gated", int'(irq), 0);
    wr(CA, 0);

    // R6 / R2: staged buffer value
    wr(LA, 5);
    wr(CA, 3);
    wr(LA, 9);
    rd(LA, v); check("R6 live count kept", v, 4);
    step(4);
    rd(LA, v); check("R6 reach zero", v, 0);
    step(1);
    rd(LA, v); check("R6 new reload", v, 9);
    step(1);
    rd(LA, v); check("R6 after reload", v, 8);
    wr(CA, 0);
    rd(LA, v); check("R7 stopped", v, 7);
    wr(LA, 12);
    rd(LA, v); check("R2 read is count", v, 7);
    wr(CA, 1);
    rd(LA, v); check("R3 restart", v, 12);
    wr(CA, 0);

    // R10: external source
    src_sel = 1'b1;
    wr(LA, 2);
    wr(CA, 1);
    rd(LA, v); check("R10 loaded", v, 2);
    step(8);
    rd(LA, v); check("R10 idle pin", v, 2);
    ext_clk_pin = 1'b1; step(6);
    rd(LA, v); check("R10 held high", v, 1);
    ext_clk_pin = 1'b0; step(5);
    rd(LA, v); check("R10 after fall", v, 1);
    pulse_ext();
    rd(LA, v); check("R10 second", v, 0);
    pulse_ext();
    rd(LA, v); check("R10 reload", v, 2);
    rd(CA, v); check("R10 flag", v, 5);
    wr(CA, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule